// File: doc/BRIEF.md
# SDRAM Write Burst Column Engine

This block sits on the device side of a synchronous DRAM. It decodes the command pins on every rising clock edge and turns WRITE commands into a stream of internal write strobes. Each strobe carries a bank, a column and the data word sampled from the DQ inputs. The first word is taken on the same edge that registers the WRITE. Each later word is taken on the next edge, at a column produced by a counter that wraps inside the burst's aligned block. In full-page mode the counter wraps over the whole page and the burst runs until another command ends it.

A new WRITE or a READ may arrive on any cycle and cuts off the running burst at once. Each WRITE carries an auto-precharge flag. A precharge request is raised together with the last strobe of a burst only when that burst runs to its full length. A per-word mask input blocks the strobe for one cycle, but the column counter still advances. The strobe outputs are registered, so they appear one cycle after the edge that sampled the data, and they drive a small storage array directly.

Top module: `sdram_wburst_engine`

## Requirements
- R1: A WRITE command (cs_n=0, ras_n=1, cas_n=0, we_n=0) sampled on a rising edge produces, right after that edge, wr_en=1 with wr_bank=cmd_bank, wr_col=cmd_col and wr_data equal to the dq value sampled on that same edge.
- R2: On each later edge of a running burst, one more word is sampled from dq. Its column is the previous column plus one, taken modulo the burst length within the aligned block, so a burst of 4 that starts at column 6 writes columns 6, 7, 4, 5.
- R3: bl_sel is sampled with the WRITE. The value 0 selects a burst of 1, 1 selects 2, 2 selects 4 and 3 selects 8. Any other value selects a full-page burst.
- R4: Once a fixed-length burst has written all its words, and while no new WRITE arrives, dq is ignored and wr_en stays 0.
- R5: A full-page burst goes on past column 255 to column 0 and continues writing until a WRITE or READ ends it.
- R6: A WRITE accepted during a running burst ends that burst at once. The word sampled with the new WRITE goes to the new bank and column, and the old burst does not resume.
- R7: A READ command (cs_n=0, ras_n=1, cas_n=0, we_n=1) ends any running write. From the edge that registers it, no strobe is produced.
- R8: When cmd_ap was 1 on the WRITE, pre_req pulses for one cycle together with the last strobe of a burst that completes its full length. The bank to close is wr_bank.
- R9: A burst cut off by a WRITE or READ never raises pre_req, and a full-page burst never raises it.
- R10: dqm=1 on a data edge keeps wr_en at 0 for that word, and the column counter still advances.
- R11: When cs_n=1, or when the pins form any pattern other than WRITE or READ, the command is ignored. An idle engine stays idle, and a running burst continues.
- R12: After reset, wr_en and pre_req are 0 and no burst is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe pin, active low |
| cas_n | input | 1 | Column strobe pin, active low |
| we_n | input | 1 | Write pin, active low |
| cmd_bank | input | 2 | Bank selected by the command |
| cmd_col | input | 8 | Start column of the burst |
| cmd_ap | input | 1 | Auto-precharge enable for this WRITE |
| bl_sel | input | 3 | Burst length code (R3) |
| dq | input | 32 | Write data |
| dqm | input | 1 | Per-word write mask, active high |
| wr_en | output | 1 | Internal write strobe |
| wr_bank | output | 2 | Bank of the strobe |
| wr_col | output | 8 | Column of the strobe |
| wr_data | output | 32 | Data of the strobe |
| pre_req | output | 1 | One-cycle precharge request for wr_bank |

## Verification
The hardest state to reach from the ports is a full-page burst that crosses the end of the page. The stimulus starts such a burst at column 254 with auto-precharge set, follows it across the wrap to columns 0, 1 and 2, and then ends it with a READ, so that the wrap, the cut-off and the missing precharge are all seen in one run. A masked word in the middle of a burst is just as hard to observe, because the advance of the counter shows only in the column of the next unmasked word, and the stimulus unmasks that word for this reason.

// File: rtl/sdwb_pkg.sv
// Shared types for the write burst engine.
package sdwb_pkg;
    // Decoded command class seen on one clock edge.
    typedef enum logic [1:0] {
        CMD_IDLE  = 2'd0,
        CMD_WRITE = 2'd1,
        CMD_READ  = 2'd2,
        CMD_OTHER = 2'd3
    } cmd_e;

    // Burst length codes; anything else means full page.
    localparam logic [2:0] BL_ONE   = 3'd0;
    localparam logic [2:0] BL_TWO   = 3'd1;
    localparam logic [2:0] BL_FOUR  = 3'd2;
    localparam logic [2:0] BL_EIGHT = 3'd3;
endpackage

// File: rtl/sdwb_cmd_decode.sv
// Command decoder: turns the active-low strobe pins into a command class.
// Assumes the pins are sampled by the caller on the rising edge.
module sdwb_cmd_decode
    import sdwb_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);
    // Classify pin pattern; only WRITE and READ matter to this block.
    always_comb begin
        if (cs_n) begin
            cmd = CMD_IDLE;
        end else begin
            unique case ({ras_n, cas_n, we_n})
                3'b100:  cmd = CMD_WRITE;
                3'b101:  cmd = CMD_READ;
                3'b111:  cmd = CMD_IDLE;
                default: cmd = CMD_OTHER;
            endcase
        end
    end
endmodule

// File: rtl/sdwb_col_step.sv
// Column stepper: increments a column inside the block selected by a wrap
// mask. Bits set in the mask count; bits clear are held.
// Assumes the mask is a contiguous run of ones from bit 0.
module sdwb_col_step #(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] col,
    input  logic [COL_W-1:0] wrap_mask,
    output logic [COL_W-1:0] col_next
);
    logic [COL_W-1:0] inc;

    // Add one, then keep only the masked low bits of the sum.
    always_comb begin
        inc      = col + COL_W'(1);
        col_next = (col & ~wrap_mask) | (inc & wrap_mask);
    end
endmodule

// File: rtl/sdwb_burst_ctrl.sv
// Burst controller: holds the burst state and the registered strobe outputs.
// Assumes the command is already decoded and that the next column is computed
// outside from wr_col and wrap_mask. Length and auto-precharge are latched
// with the WRITE.
module sdwb_burst_ctrl
    import sdwb_pkg::*;
#(
    parameter int COL_W  = 8,
    parameter int BANK_W = 2,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cmd_e              cmd,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic [COL_W-1:0]  cmd_col,
    input  logic              cmd_ap,
    input  logic [2:0]        bl_sel,
    input  logic [DATA_W-1:0] dq,
    input  logic              dqm,
    input  logic [COL_W-1:0]  col_next,
    output logic [COL_W-1:0]  wrap_mask,
    output logic              busy,
    output logic              wr_en,
    output logic [BANK_W-1:0] wr_bank,
    output logic [COL_W-1:0]  wr_col,
    output logic [DATA_W-1:0] wr_data,
    output logic              pre_req
);
    logic [COL_W-1:0] sel_mask;
    logic             sel_full;
    logic [COL_W-1:0] remain_q;
    logic             full_q;
    logic             ap_q;

    // Translate the length code into a wrap mask and a full-page flag.
    always_comb begin
        sel_full = 1'b0;
        unique case (bl_sel)
            BL_ONE:   sel_mask = '0;
            BL_TWO:   sel_mask = COL_W'(1);
            BL_FOUR:  sel_mask = COL_W'(3);
            BL_EIGHT: sel_mask = COL_W'(7);
            default: begin
                sel_mask = '1;
                sel_full = 1'b1;
            end
        endcase
    end

    // Advance the burst one word per edge; new commands take priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            full_q    <= 1'b0;
            ap_q      <= 1'b0;
            remain_q  <= '0;
            wrap_mask <= '0;
            wr_en     <= 1'b0;
            wr_bank   <= '0;
            wr_col    <= '0;
            wr_data   <= '0;
            pre_req   <= 1'b0;
        end else if (cmd == CMD_WRITE) begin
            busy      <= sel_full || (sel_mask != '0);
            full_q    <= sel_full;
            ap_q      <= cmd_ap;
            remain_q  <= sel_mask;
            wrap_mask <= sel_mask;
            wr_en     <= !dqm;
            wr_bank   <= cmd_bank;
            wr_col    <= cmd_col;
            wr_data   <= dq;
            pre_req   <= cmd_ap && !sel_full && (sel_mask == '0);
        end else if (cmd == CMD_READ) begin
            busy    <= 1'b0;
            wr_en   <= 1'b0;
            pre_req <= 1'b0;
        end else if (busy) begin
            wr_en    <= !dqm;
            wr_col   <= col_next;
            wr_data  <= dq;
            remain_q <= remain_q - COL_W'(1);
            if (!full_q && remain_q == COL_W'(1)) begin
                busy    <= 1'b0;
                pre_req <= ap_q;
            end else begin
                pre_req <= 1'b0;
            end
        end else begin
            wr_en   <= 1'b0;
            pre_req <= 1'b0;
        end
    end
endmodule

// File: rtl/sdram_wburst_engine.sv
// Write burst column engine: decodes commands and emits registered internal
// write strobes (bank, column, data) plus a precharge request for wr_bank.
// Assumes rows are already open; the strobes reach the array one cycle after
// the edge that sampled the data.
module sdram_wburst_engine
    import sdwb_pkg::*;
#(
    parameter int COL_W  = 8,
    parameter int BANK_W = 2,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic [COL_W-1:0]  cmd_col,
    input  logic              cmd_ap,
    input  logic [2:0]        bl_sel,
    input  logic [DATA_W-1:0] dq,
    input  logic              dqm,
    output logic              wr_en,
    output logic [BANK_W-1:0] wr_bank,
    output logic [COL_W-1:0]  wr_col,
    output logic [DATA_W-1:0] wr_data,
    output logic              pre_req
);
    cmd_e             cmd;
    logic [COL_W-1:0] wrap_mask;
    logic [COL_W-1:0] col_next;
    logic             busy;

    sdwb_cmd_decode u_dec (
        .cs_n (cs_n),
        .ras_n(ras_n),
        .cas_n(cas_n),
        .we_n (we_n),
        .cmd  (cmd)
    );

    sdwb_col_step #(.COL_W(COL_W)) u_step (
        .col      (wr_col),
        .wrap_mask(wrap_mask),
        .col_next (col_next)
    );

    sdwb_burst_ctrl #(
        .COL_W (COL_W),
        .BANK_W(BANK_W),
        .DATA_W(DATA_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd      (cmd),
        .cmd_bank (cmd_bank),
        .cmd_col  (cmd_col),
        .cmd_ap   (cmd_ap),
        .bl_sel   (bl_sel),
        .dq       (dq),
        .dqm      (dqm),
        .col_next (col_next),
        .wrap_mask(wrap_mask),
        .busy     (busy),
        .wr_en    (wr_en),
        .wr_bank  (wr_bank),
        .wr_col   (wr_col),
        .wr_data  (wr_data),
        .pre_req  (pre_req)
    );
endmodule

// File: rtl/sdwb_checker.sv
// Checker: temporal properties of the write burst engine, bound to its top.
module sdwb_checker #(
    parameter int COL_W  = 8,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_wr,
    input logic              cmd_rd,
    input logic [COL_W-1:0]  cmd_col,
    input logic [DATA_W-1:0] dq,
    input logic              dqm,
    input logic              busy,
    input logic              wr_en,
    input logic [COL_W-1:0]  wr_col,
    input logic [DATA_W-1:0] wr_data,
    input logic              pre_req
);
    assert_first_word_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(cmd_wr) && !$past(dqm)
        |-> wr_en && wr_col == $past(cmd_col) && wr_data == $past(dq));

    assert_col_moves_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(busy) && !$past(cmd_wr) && !$past(cmd_rd)
        |-> wr_col != $past(wr_col));

    assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(busy) && !$past(cmd_wr) |-> !wr_en && !pre_req);

    assert_read_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(cmd_rd) |-> !wr_en && !busy && !pre_req);

    assert_pre_at_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pre_req |-> !busy);

    assert_mask_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(dqm) |-> !wr_en);
endmodule

bind sdram_wburst_engine sdwb_checker #(.COL_W(COL_W), .DATA_W(DATA_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cmd_wr (cmd == sdwb_pkg::CMD_WRITE),
    .cmd_rd (cmd == sdwb_pkg::CMD_READ),
    .cmd_col(cmd_col),
    .dq     (dq),
    .dqm    (dqm),
    .busy   (busy),
    .wr_en  (wr_en),
    .wr_col (wr_col),
    .wr_data(wr_data),
    .pre_req(pre_req)
);

// File: tb/sim_sdram_wburst_engine.sv
// Directed bench: one task per scenario, each checking its own results.
module sim_sdram_wburst_engine;
    localparam int HALF = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0]  cmd_bank = '0;
    logic [7:0]  cmd_col = '0;
    logic        cmd_ap = 1'b0;
    logic [2:0]  bl_sel = '0;
    logic [31:0] dq = '0;
    logic        dqm = 1'b0;
    logic        wr_en, pre_req;
    logic [1:0]  wr_bank;
    logic [7:0]  wr_col;
    logic [31:0] wr_data;

    int total = 0;
    int bad = 0;

    always #HALF clk = ~clk;

    sdram_wburst_engine u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .cmd_bank(cmd_bank), .cmd_col(cmd_col), .cmd_ap(cmd_ap),
        .bl_sel(bl_sel), .dq(dq), .dqm(dqm), .wr_en(wr_en), .wr_bank(wr_bank),
        .wr_col(wr_col), .wr_data(wr_data), .pre_req(pre_req)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // kind: 0 NOP, 1 WRITE, 2 READ, 3 deselected WRITE pattern, 4 row-open pattern
    task automatic cyc(input int kind, input logic [1:0] b, input logic [7:0] c,
                       input logic ap, input logic [31:0] d, input logic m);
        cs_n = (kind == 3) ? 1'b1 : (kind == 0);
        ras_n = (kind == 4) ? 1'b0 : 1'b1;
        cas_n = (kind == 4 || kind == 0) ? 1'b1 : 1'b0;
        we_n  = (kind == 2 || kind == 4 || kind == 0) ? 1'b1 : 1'b0;
        cmd_bank = b; cmd_col = c; cmd_ap = ap; dq = d; dqm = m;
        @(posedge clk);
        #1;
    endtask

    task automatic word(input string req, input logic en, input logic [1:0] b,
                        input logic [7:0] c, input logic [31:0] d, input logic pre);
        chk({req, " wr_en"}, 64'(wr_en), 64'(en));
        if (en) begin
            chk({req, " wr_bank"}, 64'(wr_bank), 64'(b));
            chk({req, " wr_col"}, 64'(wr_col), 64'(c));
            chk({req, " wr_data"}, 64'(wr_data), 64'(d));
        end
        chk({req, " pre_req"}, 64'(pre_req), 64'(pre));
    endtask

    task automatic t_reset;
        chk("R12 wr_en", 64'(wr_en), 64'd0);
        chk("R12 pre_req", 64'(pre_req), 64'd0);
        cyc(0, 0, 0, 0, 32'h1111, 0);
        word("R12 idle", 0, 0, 0, 0, 0);
    endtask

    task automatic t_single;
        bl_sel = 3'd0;
        cyc(1, 2'd2, 8'd5, 1, 32'hAB00_0005, 0);
        word("R1 single", 1, 2'd2, 8'd5, 32'hAB00_0005, 1);
        cyc(0, 0, 0, 0, 32'hDEAD_0000, 0);
        word("R4 after single", 0, 0, 0, 0, 0);
    endtask

    task automatic t_burst4;
        logic [7:0] cols [4] = '{8'd6, 8'd7, 8'd4, 8'd5};
        bl_sel = 3'd2;
        for (int i = 0; i < 4; i++) begin
            cyc(i == 0 ? 1 : 0, 2'd1, 8'd6, 1, 32'hB400_0000 + 32'(i), 0);
            word("R2 R8 burst4", 1, 2'd1, cols[i], 32'hB400_0000 + 32'(i), i == 3);
        end
        cyc(0, 0, 0, 0, 32'hDEAD_0001, 0);
        word("R4 after burst4", 0, 0, 0, 0, 0);
    endtask

    task automatic t_burst8;
        bl_sel = 3'd3;
        for (int i = 0; i < 8; i++) begin
            cyc(i == 0 ? 1 : 0, 2'd0, 8'd13, 0, 32'hB800_0000 + 32'(i), 0);
            word("R3 burst8", 1, 2'd0, 8'd8 + 8'((5 + i) % 8), 32'hB800_0000 + 32'(i), 0);
        end
        cyc(0, 0, 0, 0, 32'hDEAD_0002, 0);
        word("R4 after burst8", 0, 0, 0, 0, 0);
        bl_sel = 3'd1;
        cyc(1, 2'd3, 8'd9, 1, 32'hB200_0000, 0);
        word("R3 burst2 w0", 1, 2'd3, 8'd9, 32'hB200_0000, 0);
        cyc(0, 0, 0, 0, 32'hB200_0001, 0);
        word("R3 burst2 w1", 1, 2'd3, 8'd8, 32'hB200_0001, 1);
        cyc(0, 0, 0, 0, 32'hDEAD_0003, 0);
        word("R4 after burst2", 0, 0, 0, 0, 0);
    endtask

    task automatic t_full_wrap;
        bl_sel = 3'd7;
        for (int i = 0; i < 5; i++) begin
            cyc(i == 0 ? 1 : 0, 2'd3, 8'd254, 1, 32'hF000_0000 + 32'(i), 0);
            word("R5 full page", 1, 2'd3, 8'(254 + i), 32'hF000_0000 + 32'(i), 0);
        end
        cyc(2, 0, 0, 0, 32'hDEAD_0004, 0);
        word("R7 R9 read ends full", 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 32'hDEAD_0005, 0);
        word("R7 stays ended", 0, 0, 0, 0, 0);
        bl_sel = 3'd5;
        cyc(1, 2'd0, 8'd255, 0, 32'hF500_0000, 0);
        word("R3 code5 w0", 1, 2'd0, 8'd255, 32'hF500_0000, 0);
        for (int i = 1; i < 10; i++) begin
            cyc(0, 0, 0, 0, 32'hF500_0000 + 32'(i), 0);
            word("R3 R5 code5 runs", 1, 2'd0, 8'(i - 1), 32'hF500_0000 + 32'(i), 0);
        end
        cyc(2, 0, 0, 0, 0, 0);
        word("R7 read ends code5", 0, 0, 0, 0, 0);
    endtask

    task automatic t_truncate;
        bl_sel = 3'd3;
        cyc(1, 2'd0, 8'd10, 1, 32'hC000_0000, 0);
        word("R6 old w0", 1, 2'd0, 8'd10, 32'hC000_0000, 0);
        cyc(0, 0, 0, 0, 32'hC000_0001, 0);
        word("R6 old w1", 1, 2'd0, 8'd11, 32'hC000_0001, 0);
        bl_sel = 3'd0;
        cyc(1, 2'd3, 8'd40, 0, 32'hC100_0000, 0);
        word("R6 R9 new write", 1, 2'd3, 8'd40, 32'hC100_0000, 0);
        cyc(1, 2'd1, 8'd77, 0, 32'hC200_0000, 0);
        word("R6 other bank", 1, 2'd1, 8'd77, 32'hC200_0000, 0);
        cyc(0, 0, 0, 0, 32'hDEAD_0006, 0);
        word("R6 old not resumed", 0, 0, 0, 0, 0);
    endtask

    task automatic t_mask;
        bl_sel = 3'd2;
        cyc(1, 2'd2, 8'd20, 0, 32'hD000_0000, 0);
        word("R10 w0", 1, 2'd2, 8'd20, 32'hD000_0000, 0);
        cyc(0, 0, 0, 0, 32'hD000_0001, 1);
        word("R10 masked", 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 32'hD000_0002, 0);
        word("R10 advanced", 1, 2'd2, 8'd22, 32'hD000_0002, 0);
        cyc(0, 0, 0, 0, 32'hD000_0003, 0);
        word("R10 last", 1, 2'd2, 8'd23, 32'hD000_0003, 0);
    endtask

    task automatic t_ignored;
        bl_sel = 3'd0;
        cyc(3, 2'd1, 8'd3, 1, 32'hE000_0000, 0);
        word("R11 deselect", 0, 0, 0, 0, 0);
        cyc(4, 2'd1, 8'd3, 1, 32'hE000_0001, 0);
        word("R11 row open", 0, 0, 0, 0, 0);
        bl_sel = 3'd2;
        cyc(1, 2'd0, 8'd0, 0, 32'hE100_0000, 0);
        word("R11 start", 1, 2'd0, 8'd0, 32'hE100_0000, 0);
        cyc(4, 2'd3, 8'd99, 0, 32'hE100_0001, 0);
        word("R11 burst continues", 1, 2'd0, 8'd1, 32'hE100_0001, 0);
        cyc(3, 2'd3, 8'd99, 0, 32'hE100_0002, 0);
        word("R11 burst continues desel", 1, 2'd0, 8'd2, 32'hE100_0002, 0);
        cyc(2, 0, 0, 0, 32'hE100_0003, 0);
        word("R7 read mid burst", 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 32'hE100_0004, 0);
        word("R7 no resume", 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        t_reset();
        t_single();
        t_burst4();
        t_burst8();
        t_full_wrap();
        t_truncate();
        t_mask();
        t_ignored();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(HALF * 2 * 20000);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule